// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the state of every bank of an eight-bank DDR3 device by watching the command pins on each clock. It serves two purposes. It can act as a protocol monitor placed beside a controller, or it can hold the bank bookkeeping inside a controller. Each bank has a small readiness word. An activate fills the word with ones over a fixed number of idle clocks. A precharge drains it back to zeros over the same number. One register therefore gives the open, ready and idle status together with the timing since the last open or close.

The tracker also keeps three timers. A per-bank write-recovery count catches reads issued too soon after a write. A global count since the last refresh catches two faults: an activate issued too early after a refresh, and a refresh interval that runs too long. Each kind of illegal command sets its own error bit. An error bit stays set until the synchronous reset clears it. The block does not handle the data path and does not schedule refreshes.

Top module: `dram_bank_tracker`

## Requirements
- R1: A command is acted on only when `mem_reset_n` and `mem_cke` are both high. Otherwise bank states and rows hold. The command is taken from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode set, 0110 calibration, 0111 idle. With cs_n high the cycle counts as an idle cycle.
- R2: An activate to bank `mem_ba` sets that bank's readiness word to 1 and latches `mem_addr[14:0]` as its open row. On the next cycle `bank_open` is high and `bank_idle` is low for that bank.
- R3: Each idle cycle shifts a bank's 6-bit readiness word left and copies the new bit 1 into bit 0. Mode-set, calibration and refresh cycles hold the word. After an activate, `bank_ready` rises after exactly 5 idle ticks. After a precharge of a ready bank, `bank_idle` rises after exactly 5 idle ticks.
- R4: A read or write to a bank whose readiness word is not all ones sets `err_flags[0]`.
- R5: An activate to a bank whose readiness word is not all zeros sets `err_flags[1]`.
- R6: A refresh while any bank's readiness word is non-zero sets `err_flags[2]`.
- R7: A precharge with `mem_addr[10]` high clears bit 0 of every bank. Without it, only the addressed bank is cleared and every other bank takes an idle tick. Read, write and activate also give an idle tick to the banks they do not address.
- R8: A read to a bank issued 1 to 10 cycles after a write to the same bank sets `err_flags[3]`. A read issued 11 cycles after the write does not.
- R9: After a refresh at cycle T, an activate at cycle T+k with k < 64 sets `err_flags[4]`. An activate at k = 64 does not.
- R10: Once a refresh has been seen, any non-refresh cycle more than 1560 cycles after the latest refresh sets `err_flags[5]`. A refresh at exactly 1560 cycles is legal.
- R11: `rst` clears all states, rows, timers and errors. Every error bit stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_reset_n | input | 1 | Device reset pin, active low |
| mem_cke | input | 1 | Clock enable pin |
| mem_cs_n | input | 1 | Chip select, active low |
| mem_ras_n | input | 1 | Row strobe, active low |
| mem_cas_n | input | 1 | Column strobe, active low |
| mem_we_n | input | 1 | Write enable, active low |
| mem_ba | input | 3 | Bank address |
| mem_addr | input | 15 | Row/column address; bit 10 selects all-bank precharge |
| bank_open | output | 8 | Readiness word bit 0 per bank |
| bank_ready | output | 8 | Readiness word all ones per bank |
| bank_idle | output | 8 | Readiness word all zeros per bank |
| open_row | output | 120 | Latched row per bank, bank b at bits [15b+14:15b] |
| err_flags | output | 6 | Sticky error bits as listed in R4 to R10 |

## Verification
The stimulus mixes plain idle cycles with deselect cycles. It also drives cycles with reset or clock-enable low, which shows whether gated cycles are wrongly treated as idle ticks. Single-bank and all-bank precharges are run against two open banks, so a precharge that reaches the wrong banks shows up. The timing rules are each probed one cycle on either side of their limit: the fifth fill tick, the eleventh cycle after a write, activate at 63 and 64 cycles after a refresh, and refresh at 1560 and 1561 cycles. These tell an off-by-one from a correct count.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

   typedef enum logic [3:0] {
      OP_MRS  = 4'd0,
      OP_REF  = 4'd1,
      OP_PRE  = 4'd2,
      OP_ACT  = 4'd3,
      OP_WR   = 4'd4,
      OP_RD   = 4'd5,
      OP_ZQ   = 4'd6,
      OP_NOP  = 4'd7,
      OP_HOLD = 4'd8
   } bank_op_e;

   localparam int ERR_RW_NOT_READY = 0;
   localparam int ERR_ACT_BUSY     = 1;
   localparam int ERR_REF_BUSY     = 2;
   localparam int ERR_RD_RECOVERY  = 3;
   localparam int ERR_ACT_EARLY    = 4;
   localparam int ERR_REF_LATE     = 5;
   localparam int ERR_W            = 6;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
   import bank_trk_pkg::*;
(
   input  logic     pin_reset_n,
   input  logic     pin_cke,
   input  logic     pin_cs_n,
   input  logic     pin_ras_n,
   input  logic     pin_cas_n,
   input  logic     pin_we_n,
   output bank_op_e op
);

   logic [5:0] code;
   assign code = {~pin_reset_n, ~pin_cke, pin_cs_n, pin_ras_n, pin_cas_n, pin_we_n};

   always_comb begin
      if (code[5:4] != 2'b00) begin
         op = OP_HOLD;
      end else if (code[3]) begin
         op = OP_NOP;
      end else begin
         case (code[2:0])
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_MRS;
            3'b110:  op = OP_ZQ;
            default: op = OP_NOP;
         endcase
      end
   end

endmodule

// File: rtl/bank_slot.sv
module bank_slot
   import bank_trk_pkg::*;
#(
   parameter int PRE_BITS = 6,
   parameter int ROW_W    = 15,
   parameter int WR_RECOV = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  bank_op_e         op,
   input  logic             hit,
   input  logic             pre_all,
   input  logic [ROW_W-1:0] row_in,
   output logic             open_o,
   output logic             ready_o,
   output logic             idle_o,
   output logic [ROW_W-1:0] row_o,
   output logic             e_rw,
   output logic             e_act,
   output logic             e_ref,
   output logic             e_rdrec
);

   localparam int WC_W = $clog2(WR_RECOV + 1);
   localparam logic [PRE_BITS-1:0] FULL = {PRE_BITS{1'b1}};
   localparam logic [WC_W-1:0] WC_LOAD = WC_W'(WR_RECOV - 1);

   if (PRE_BITS < 2) begin : g_bad_pre
      $error("bank_slot: PRE_BITS must be at least 2");
   end
   if (WR_RECOV < 1) begin : g_bad_wr
      $error("bank_slot: WR_RECOV must be at least 1");
   end

   logic [PRE_BITS-1:0] st_q, st_d, st_tick;
   logic [ROW_W-1:0]    row_q;
   logic [WC_W-1:0]     wc_q, wc_d;

   assign st_tick = {st_q[PRE_BITS-2:0], st_q[0]};

   always_comb begin
      st_d    = st_q;
      wc_d    = (wc_q != '0) ? wc_q - 1'b1 : wc_q;
      e_rw    = 1'b0;
      e_act   = 1'b0;
      e_ref   = 1'b0;
      e_rdrec = 1'b0;
      case (op)
         OP_ACT: begin
            if (hit) begin
               e_act = (st_q != '0);
               st_d  = PRE_BITS'(1);
            end else begin
               st_d = st_tick;
            end
         end
         OP_RD: begin
            if (hit) begin
               e_rw    = (st_q != FULL);
               e_rdrec = (wc_q != '0);
            end else begin
               st_d = st_tick;
            end
         end
         OP_WR: begin
            if (hit) begin
               e_rw = (st_q != FULL);
               wc_d = WC_LOAD;
            end else begin
               st_d = st_tick;
            end
         end
         OP_PRE: begin
            if (hit || pre_all) st_d = {st_q[PRE_BITS-1:1], 1'b0};
            else                st_d = st_tick;
         end
         OP_REF:  e_ref = (st_q != '0);
         OP_NOP:  st_d = st_tick;
         default: st_d = st_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= '0;
         row_q <= '0;
         wc_q  <= '0;
      end else begin
         st_q <= st_d;
         wc_q <= wc_d;
         if (op == OP_ACT && hit) row_q <= row_in;
      end
   end

   assign open_o  = st_q[0];
   assign ready_o = (st_q == FULL);
   assign idle_o  = (st_q == '0);
   assign row_o   = row_q;

   // R2
   act_load_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ACT && hit) |=> (row_o == $past(row_in) && open_o && !ready_o && !idle_o));

   // R3
   ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_o) |-> $past(open_o));

   // R8
   wr_recov_load_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_WR && hit) |=> (wc_q == WC_LOAD));

   // R1
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_HOLD) |=> ($stable(open_o) && $stable(ready_o) && $stable(row_o)));

endmodule

// File: rtl/bank_refresh_watch.sv
module bank_refresh_watch
   import bank_trk_pkg::*;
#(
   parameter int RFC_CLKS  = 64,
   parameter int REFI_CLKS = 1560
) (
   input  logic     clk,
   input  logic     rst,
   input  bank_op_e op,
   output logic     e_early,
   output logic     e_late
);

   localparam int CNT_MAX = REFI_CLKS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (RFC_CLKS >= REFI_CLKS) begin : g_bad_window
      $error("bank_refresh_watch: RFC_CLKS must be below REFI_CLKS");
   end

   logic [CNT_W-1:0] since_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (op == OP_REF) begin
         since_q <= CNT_W'(1);
         seen_q  <= 1'b1;
      end else if (since_q < CNT_W'(CNT_MAX)) begin
         since_q <= since_q + 1'b1;
      end
   end

   assign e_early = seen_q && (op == OP_ACT) && (since_q < CNT_W'(RFC_CLKS));
   assign e_late  = seen_q && (op != OP_REF) && (since_q > CNT_W'(REFI_CLKS));

   // R9
   ref_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_REF) |=> (since_q == CNT_W'(1) && seen_q));

   // R10
   late_armed_chk: assert property (@(posedge clk) disable iff (rst)
      e_late |-> (seen_q && since_q == CNT_W'(CNT_MAX)));

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
   import bank_trk_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int BA_W      = 3,
   parameter int ROW_W     = 15,
   parameter int AP_BIT    = 10,
   parameter int PRE_BITS  = 6,
   parameter int WR_RECOV  = 11,
   parameter int RFC_CLKS  = 64,
   parameter int REFI_CLKS = 1560
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       mem_reset_n,
   input  logic                       mem_cke,
   input  logic                       mem_cs_n,
   input  logic                       mem_ras_n,
   input  logic                       mem_cas_n,
   input  logic                       mem_we_n,
   input  logic [BA_W-1:0]            mem_ba,
   input  logic [ROW_W-1:0]           mem_addr,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS-1:0]       bank_ready,
   output logic [NUM_BANKS-1:0]       bank_idle,
   output logic [NUM_BANKS*ROW_W-1:0] open_row,
   output logic [ERR_W-1:0]           err_flags
);

   if (NUM_BANKS > (1 << BA_W)) begin : g_bad_banks
      $error("dram_bank_tracker: NUM_BANKS exceeds bank address range");
   end
   if (AP_BIT >= ROW_W) begin : g_bad_ap
      $error("dram_bank_tracker: AP_BIT outside address width");
   end

   bank_op_e op;
   logic [NUM_BANKS-1:0] e_rw, e_act, e_ref, e_rdrec;
   logic                 e_early, e_late;
   logic [ERR_W-1:0]     err_now, err_q;

   bank_cmd_decode u_dec (
      .pin_reset_n (mem_reset_n),
      .pin_cke     (mem_cke),
      .pin_cs_n    (mem_cs_n),
      .pin_ras_n   (mem_ras_n),
      .pin_cas_n   (mem_cas_n),
      .pin_we_n    (mem_we_n),
      .op          (op)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bank_slot #(
         .PRE_BITS (PRE_BITS),
         .ROW_W    (ROW_W),
         .WR_RECOV (WR_RECOV)
      ) u_slot (
         .clk     (clk),
         .rst     (rst),
         .op      (op),
         .hit     (mem_ba == BA_W'(b)),
         .pre_all (mem_addr[AP_BIT]),
         .row_in  (mem_addr),
         .open_o  (bank_open[b]),
         .ready_o (bank_ready[b]),
         .idle_o  (bank_idle[b]),
         .row_o   (open_row[b*ROW_W +: ROW_W]),
         .e_rw    (e_rw[b]),
         .e_act   (e_act[b]),
         .e_ref   (e_ref[b]),
         .e_rdrec (e_rdrec[b])
      );
   end

   bank_refresh_watch #(
      .RFC_CLKS  (RFC_CLKS),
      .REFI_CLKS (REFI_CLKS)
   ) u_ref (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .e_early (e_early),
      .e_late  (e_late)
   );

   always_comb begin
      err_now                   = '0;
      err_now[ERR_RW_NOT_READY] = |e_rw;
      err_now[ERR_ACT_BUSY]     = |e_act;
      err_now[ERR_REF_BUSY]     = |e_ref;
      err_now[ERR_RD_RECOVERY]  = |e_rdrec;
      err_now[ERR_ACT_EARLY]    = e_early;
      err_now[ERR_REF_LATE]     = e_late;
   end

   always_ff @(posedge clk) begin
      if (rst) err_q <= '0;
      else     err_q <= err_q | err_now;
   end

   assign err_flags = err_q;

   // R11
   sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
      ((err_flags & $past(err_flags)) == $past(err_flags)));

   // R6
   ref_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_REF && bank_idle != {NUM_BANKS{1'b1}}) |=> err_flags[ERR_REF_BUSY]);

endmodule

// File: tb/dram_bank_tracker_tb.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb;

   localparam int NB = 8;
   localparam int RW = 15;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rn = 1'b1, ck = 1'b1, cs = 1'b1, ras = 1'b1, cas = 1'b1, we = 1'b1;
   logic [2:0]  ba = '0;
   logic [14:0] addr = '0;
   logic [NB-1:0] b_open, b_ready, b_idle;
   logic [NB*RW-1:0] rows;
   logic [5:0] errs;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dram_bank_tracker u_dut (
      .clk (clk), .rst (rst),
      .mem_reset_n (rn), .mem_cke (ck), .mem_cs_n (cs),
      .mem_ras_n (ras), .mem_cas_n (cas), .mem_we_n (we),
      .mem_ba (ba), .mem_addr (addr),
      .bank_open (b_open), .bank_ready (b_ready), .bank_idle (b_idle),
      .open_row (rows), .err_flags (errs)
   );

   // behavioural reference model
   int m_st [NB];
   int m_row[NB];
   int m_wc [NB];
   int m_since;
   bit m_seen;
   bit [5:0] m_err;

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_row[b] = 0; m_wc[b] = 0; end
      m_since = 0; m_seen = 0; m_err = '0;
   endtask

   function automatic int fill(int s);
      return ((s << 1) | (s & 1)) & 63;
   endfunction

   task automatic model_step();
      string kind;
      bit [5:0] e = '0;
      if (!rn || !ck)   kind = "hold";
      else if (cs)      kind = "nop";
      else begin
         case ({ras, cas, we})
            3'b011: kind = "act";
            3'b101: kind = "rd";
            3'b100: kind = "wr";
            3'b010: kind = "pre";
            3'b001: kind = "ref";
            3'b111: kind = "nop";
            default: kind = "hold";
         endcase
      end
      if (kind == "act" && m_seen && m_since < 64) e[4] = 1;
      if (kind != "ref" && m_seen && m_since > 1560) e[5] = 1;
      if (kind == "ref") begin m_since = 1; m_seen = 1; end
      else if (m_since < 1561) m_since++;
      for (int b = 0; b < NB; b++) begin
         bit hit = (int'(ba) == b);
         int s = m_st[b];
         int w = (m_wc[b] > 0) ? m_wc[b] - 1 : 0;
         if (kind == "act") begin
            if (hit) begin if (m_st[b] != 0) e[1] = 1; s = 1; m_row[b] = int'(addr); end
            else s = fill(m_st[b]);
         end else if (kind == "rd") begin
            if (hit) begin if (m_st[b] != 63) e[0] = 1; if (m_wc[b] != 0) e[3] = 1; end
            else s = fill(m_st[b]);
         end else if (kind == "wr") begin
            if (hit) begin if (m_st[b] != 63) e[0] = 1; w = 10; end
            else s = fill(m_st[b]);
         end else if (kind == "pre") begin
            if (hit || addr[10]) s = m_st[b] & ~1;
            else s = fill(m_st[b]);
         end else if (kind == "ref") begin
            if (m_st[b] != 0) e[2] = 1;
         end else if (kind == "nop") begin
            s = fill(m_st[b]);
         end
         m_st[b] = s;
         m_wc[b] = w;
      end
      m_err |= e;
   endtask

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_model();
      logic [NB-1:0] eo, er, ei;
      bit rows_ok = 1;
      for (int b = 0; b < NB; b++) begin
         eo[b] = m_st[b][0];
         er[b] = (m_st[b] == 63);
         ei[b] = (m_st[b] == 0);
         if (int'(rows[b*RW +: RW]) != m_row[b]) rows_ok = 0;
      end
      check("R2 R3 R7 model flags", {b_open, b_ready, b_idle}, {eo, er, ei});
      check("R2 model rows", int'(rows_ok), 1);
      check("R4 R5 R6 R8 R9 R10 model errors", errs, m_err);
   endtask

   task automatic pins(logic c, logic r, logic a, logic w, logic [2:0] b, logic [14:0] ad);
      cs = c; ras = r; cas = a; we = w; ba = b; addr = ad;
   endtask

   task automatic step();
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      compare_model();
   endtask

   task automatic nop(int n);
      for (int i = 0; i < n; i++) begin pins(0, 1, 1, 1, 0, 0); step(); end
   endtask
   task automatic act(logic [2:0] b, logic [14:0] r);  pins(0, 0, 1, 1, b, r); step(); endtask
   task automatic rd(logic [2:0] b);                   pins(0, 1, 0, 1, b, 0); step(); endtask
   task automatic wr(logic [2:0] b);                   pins(0, 1, 0, 0, b, 0); step(); endtask
   task automatic pre(logic [2:0] b, logic all);       pins(0, 0, 1, 0, b, {4'b0, all, 10'b0}); step(); endtask
   task automatic refr();                              pins(0, 0, 0, 1, 0, 0); step(); endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; rn = 1; ck = 1; pins(1, 1, 1, 1, 0, 0);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 0;
      model_reset();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      // R11 reset state
      do_reset();
      check("R11 reset errors", errs, 0);
      check("R11 reset idle", b_idle, 8'hFF);
      check("R11 reset open", b_open, 0);

      // R1 gated cycles do nothing
      rn = 0; act(3, 15'h1111);
      check("R1 reset_n low ignored", b_idle[3], 1);
      rn = 1; ck = 0; act(3, 15'h2222);
      check("R1 cke low ignored", b_idle[3], 1);
      check("R1 row unchanged", rows[3*RW +: RW], 0);
      ck = 1;

      // R2 activate
      act(3, 15'h5A5A);
      check("R2 open after act", b_open[3], 1);
      check("R2 row latched", rows[3*RW +: RW], 15'h5A5A);
      check("R2 not idle", b_idle[3], 0);

      // R4 read too early
      nop(2);
      rd(3);
      check("R4 read before ready", errs[0], 1);
      nop(3);
      check("R11 error sticky", errs[0], 1);
      do_reset();
      check("R11 reset clears", errs, 0);

      // R3 fill with idle and deselect mixed
      act(1, 15'h0042);
      nop(2);
      pins(1, 0, 0, 0, 1, 0); step();  // deselect, counts as idle (R1)
      nop(1);
      check("R3 not ready after 4 ticks", b_ready[1], 0);
      nop(1);
      check("R3 ready after 5 ticks", b_ready[1], 1);

      // R8 read too soon after write
      wr(1);
      check("R4 write to ready bank legal", errs[0], 0);
      nop(3);
      rd(1);
      check("R8 read 4 cycles after write", errs[3], 1);
      do_reset();
      act(1, 15'h0042);
      nop(5);
      wr(1);
      nop(10);
      rd(1);
      check("R8 read 11 cycles after write legal", errs, 0);

      // R7 single-bank and all-bank precharge
      do_reset();
      act(0, 15'h0100);
      act(2, 15'h0200);
      nop(5);
      check("R7 both ready", {b_ready[2], b_ready[0]}, 2'b11);
      pre(0, 0);
      check("R7 bank0 closed", b_open[0], 0);
      check("R7 bank2 untouched", {b_open[2], b_ready[2]}, 2'b11);
      nop(4);
      check("R3 drain not idle at 4", b_idle[0], 0);
      nop(1);
      check("R3 drain idle at 5", b_idle[0], 1);
      pre(5, 1);
      check("R7 precharge all closes bank2", b_open[2], 0);
      nop(1);
      act(2, 15'h0300);
      check("R5 act while draining", errs[1], 1);

      // R6 refresh with open bank
      do_reset();
      act(4, 15'h0004);
      nop(1);
      refr();
      check("R6 refresh with open bank", errs[2], 1);

      // R9 activate too early
      do_reset();
      refr();
      nop(62);
      act(0, 15'h0001);
      check("R9 act at 63 after refresh", errs[4], 1);
      do_reset();
      refr();
      nop(63);
      act(0, 15'h0001);
      check("R9 act at 64 after refresh legal", errs, 0);

      // R10 refresh interval
      do_reset();
      refr();
      nop(1559);
      refr();
      check("R10 refresh at 1560 legal", errs, 0);
      nop(1560);
      check("R10 no error at 1560 idle", errs[5], 0);
      nop(1);
      check("R10 late at 1561", errs[5], 1);

      summary();
   end

endmodule